// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block turns a data-memory access from a small controller core into a location in a 512-byte register space. That space is split into four banks of 128 bytes. The core gives either a 7-bit direct offset with two bank bits, or an 8-bit pointer with a single high bit. The block forms the 9-bit effective address from these. It then sorts the access into one of four regions: special-function register, general-purpose RAM, shared RAM that every bank mirrors, or unimplemented space.

For special-function accesses it raises a select and gives the bank and the 5-bit offset inside that bank, so that the register logic outside can respond. For RAM accesses it gives the physical byte index. It also holds the backing byte array. Writes to the array are synchronous and reads are combinational. Unimplemented space reads as zero, and writes to it are dropped. Every access is a plain one-cycle control transaction: there is no handshake, and the result is valid in the same cycle as the address.

Top module: `bfile_decoder`

## Requirements
- R1: The effective address `eff_addr` is {dir_bank, dir_off} when `acc_indirect` is 0, and {ind_bank, ind_ptr} when it is 1. Bits [8:7] are the bank and bits [6:0] are the offset within the bank.
- R2: An offset of 00h-1Fh in any bank is a special-function access. `region` = 0, `sfr_sel` = 1, `sfr_bank` = bank, `sfr_off` = offset[4:0], and `rd_data` = 0.
- R3: In bank 0, offsets 20h-6Fh are general RAM. `region` = 1, `ram_hit` = 1, and `ram_idx` = offset - 20h.
- R4: In every bank, offsets 70h-7Fh are shared RAM. `region` = 2 and `ram_idx` = 50h + (offset - 70h), so 7xh, Fxh, 17xh and 1Fxh all reach the same byte.
- R5: With `BANK1_WIDE` = 1 (the default), bank-1 offsets 20h-6Fh (addresses A0h-EFh) are general RAM with `region` = 1 and `ram_idx` = 60h + (offset - 20h). With `BANK1_WIDE` = 0, only offsets 20h-3Fh are RAM.
- R6: Any other location is unimplemented. `region` = 3, `rd_zero` = 1, `ram_hit` = 0 and `rd_data` = 0. Exactly one of `sfr_sel`, `ram_hit` and `rd_zero` is high for every access.
- R7: A write to a special-function or unimplemented location changes no RAM byte.
- R8: When `wr_en` is high and `ram_hit` is high, `wr_data` is stored at the rising edge. `rd_data` shows the stored byte of the addressed location combinationally.
- R9: After reset every RAM byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the RAM |
| acc_indirect | input | 1 | 1 = pointer access, 0 = direct access |
| dir_bank | input | 2 | Bank bits for direct access |
| dir_off | input | 7 | Offset for direct access |
| ind_bank | input | 1 | High address bit for pointer access |
| ind_ptr | input | 8 | Pointer value |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| eff_addr | output | 9 | Effective address |
| region | output | 2 | 0 SFR, 1 general RAM, 2 shared RAM, 3 unimplemented |
| sfr_sel | output | 1 | Special-function register addressed |
| sfr_bank | output | 2 | Bank of the addressed special-function register |
| sfr_off | output | 5 | Offset of the special-function register within its bank |
| ram_hit | output | 1 | RAM byte addressed |
| ram_idx | output | 8 | Physical RAM index |
| rd_zero | output | 1 | Unimplemented location; read forced to zero |
| rd_data | output | 8 | Read data |

## Verification
A wrong region decode appears on `region`, `ram_idx` or `rd_zero` in the same cycle as the address, because all of the decode is combinational. A wrong index, or a write that should have been dropped but was not, appears only when that RAM byte is read again later. For this reason the bench keeps a byte model of the whole array. It scans every physical byte after the write-discard and alias cases, so that a corrupted byte is found even when it was not the byte just accessed.

// File: rtl/bfile_pkg.sv
package bfile_pkg;
  typedef enum logic [1:0] {
    REG_SFR    = 2'd0,
    REG_GPR    = 2'd1,
    REG_SHARED = 2'd2,
    REG_VOID   = 2'd3
  } region_e;

  localparam int EFF_W   = 9;
  localparam int OFF_W   = 7;
  localparam int BANK_W  = 2;
  localparam int DATA_W  = 8;
  localparam int SFR_SPAN    = 32;
  localparam int GPR_BASE    = 32;
  localparam int SHARED_BASE = 112;
  localparam int BANK_SIZE   = 128;
endpackage

// File: rtl/bfile_addr_mux.sv
module bfile_addr_mux
  import bfile_pkg::*;
(
  input  logic              indirect,
  input  logic [BANK_W-1:0] dbank,
  input  logic [OFF_W-1:0]  doff,
  input  logic              ihi,
  input  logic [OFF_W:0]    iptr,
  output logic [EFF_W-1:0]  eff
);
  always_comb begin
    if (indirect) eff = {ihi, iptr};
    else          eff = {dbank, doff};
  end
endmodule

// File: rtl/bfile_classify.sv
module bfile_classify
  import bfile_pkg::*;
#(
  parameter bit BANK1_WIDE = 1'b1,
  parameter int IDX_W      = 8,
  parameter int DEPTH      = 176
) (
  input  logic [EFF_W-1:0]  eff,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic [BANK_W-1:0] bank,
  output logic [4:0]        sfr_off
);
  localparam int B0_BYTES   = BANK_SIZE - GPR_BASE;
  localparam int SHARED_IDX = SHARED_BASE - GPR_BASE;
  localparam int B1_END     = BANK1_WIDE ? SHARED_BASE : 64;

  logic [OFF_W-1:0] off;
  assign bank    = eff[EFF_W-1 -: BANK_W];
  assign off     = eff[OFF_W-1:0];
  assign sfr_off = off[4:0];

  always_comb begin
    region = REG_VOID;
    idx    = '0;
    if (int'(off) < SFR_SPAN) begin
      region = REG_SFR;
    end else if (int'(off) >= SHARED_BASE) begin
      region = REG_SHARED;
      idx    = IDX_W'(SHARED_IDX + int'(off) - SHARED_BASE);
    end else if (bank == 2'd0) begin
      region = REG_GPR;
      idx    = IDX_W'(int'(off) - GPR_BASE);
    end else if (bank == 2'd1 && int'(off) < B1_END) begin
      region = REG_GPR;
      idx    = IDX_W'(B0_BYTES + int'(off) - GPR_BASE);
    end
  end

  always_comb begin
    if (region == REG_SHARED) assert_shared_top_R4: assert (off[6:4] == 3'b111);
    if (region == REG_GPR || region == REG_SHARED)
      assert_idx_range_R5: assert (int'(idx) < DEPTH);
  end
endmodule

// File: rtl/bfile_ram.sv
module bfile_ram #(
  parameter int DEPTH  = 176,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && int'(idx) < DEPTH) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;

  assert_wr_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && idx == $past(idx)) |-> rdata == $past(wdata));
endmodule

// File: rtl/bfile_decoder.sv
module bfile_decoder
  import bfile_pkg::*;
#(
  parameter bit BANK1_WIDE = 1'b1,
  parameter int IDX_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_indirect,
  input  logic [1:0]        dir_bank,
  input  logic [6:0]        dir_off,
  input  logic              ind_bank,
  input  logic [7:0]        ind_ptr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [8:0]        eff_addr,
  output logic [1:0]        region,
  output logic              sfr_sel,
  output logic [1:0]        sfr_bank,
  output logic [4:0]        sfr_off,
  output logic              ram_hit,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              rd_zero,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = (BANK_SIZE - GPR_BASE) + (BANK1_WIDE ? (SHARED_BASE - GPR_BASE) : 32);

  region_e           reg_q;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        bank;
  logic [DATA_W-1:0] ram_q;

  bfile_addr_mux u_mux (
    .indirect(acc_indirect), .dbank(dir_bank), .doff(dir_off),
    .ihi(ind_bank), .iptr(ind_ptr), .eff(eff_addr)
  );

  bfile_classify #(.BANK1_WIDE(BANK1_WIDE), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_cls (
    .eff(eff_addr), .region(reg_q), .idx(idx), .bank(bank), .sfr_off(sfr_off)
  );

  assign region   = reg_q;
  assign sfr_sel  = (reg_q == REG_SFR);
  assign ram_hit  = (reg_q == REG_GPR) || (reg_q == REG_SHARED);
  assign rd_zero  = (reg_q == REG_VOID);
  assign sfr_bank = bank;
  assign ram_idx  = idx;

  bfile_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_en && ram_hit), .idx(idx),
    .wdata(wr_data), .rdata(ram_q)
  );

  assign rd_data = ram_hit ? ram_q : '0;

  assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sfr_sel, ram_hit, rd_zero}));
  assert_void_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> rd_data == 8'h00);
  assert_sfr_low_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> eff_addr[6:5] == 2'b00 && rd_data == 8'h00);
endmodule

// File: tb/tb_bfile_decoder.sv
module tb_bfile_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_indirect = 0, ind_bank = 0, wr_en = 0;
  logic [1:0] dir_bank = 0;
  logic [6:0] dir_off = 0;
  logic [7:0] ind_ptr = 0, wr_data = 0;
  logic [8:0] eff_addr;
  logic [1:0] region, sfr_bank;
  logic sfr_sel, ram_hit, rd_zero;
  logic [4:0] sfr_off;
  logic [7:0] ram_idx, rd_data;

  int checks = 0, errors = 0;
  logic [7:0] model [176];
  bit done = 0;

  bfile_decoder dut (.*);

  always #2 clk = ~clk;

  function automatic int exp_region(input logic [8:0] a);
    int o = int'(a[6:0]);
    if (o < 32) return 0;
    if (o >= 112) return 2;
    if (a[8:7] == 2'd0) return 1;
    if (a[8:7] == 2'd1) return 1;
    return 3;
  endfunction

  function automatic int exp_idx(input logic [8:0] a);
    int o = int'(a[6:0]);
    if (o >= 112) return 80 + o - 112;
    if (a[8:7] == 2'd0) return o - 32;
    return 96 + o - 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit ind, input logic [1:0] b, input logic [6:0] o,
                        input logic ib, input logic [7:0] p, input bit we, input logic [7:0] d);
    logic [8:0] a;
    int r, ix, exp_rd;
    @(negedge clk);
    acc_indirect = ind; dir_bank = b; dir_off = o; ind_bank = ib; ind_ptr = p;
    wr_en = we; wr_data = d;
    a = ind ? {ib, p} : {b, o};
    r = exp_region(a);
    ix = (r == 1 || r == 2) ? exp_idx(a) : 0;
    exp_rd = (r == 1 || r == 2) ? int'(model[ix]) : 0;
    #1;
    chk(eff_addr == a, "R1 eff_addr", eff_addr, a);
    chk(int'(region) == r, (r == 0) ? "R2 region" : (r == 2) ? "R4 region" : (r == 3) ? "R6 region" : "R3/R5 region", region, r);
    if (r == 0) begin
      chk(sfr_sel && sfr_bank == a[8:7] && sfr_off == a[4:0], "R2 sfr select/bank/off",
          {sfr_sel, sfr_bank, sfr_off}, {1'b1, a[8:7], a[4:0]});
    end
    if (r == 1 || r == 2)
      chk(ram_hit && int'(ram_idx) == ix, (r == 2) ? "R4 ram_idx" : "R3/R5 ram_idx", ram_idx, ix);
    if (r == 3) chk(rd_zero && !ram_hit, "R6 rd_zero", rd_zero, 1);
    chk(int'(rd_data) == exp_rd, "R8 rd_data", rd_data, exp_rd);
    if (we && (r == 1 || r == 2)) model[ix] = d;
  endtask

  task automatic scan_all(input string tag);
    for (int i = 0; i < 176; i++) begin
      if (i < 96) access(0, 2'd0, 7'(32 + i), 0, 0, 0, 0);
      else        access(0, 2'd1, 7'(32 + i - 96), 0, 0, 0, 0);
    end
    $display("scan done: %s", tag);
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    for (int i = 0; i < 176; i++) model[i] = 8'h00;
    // R9: drive writes during reset; none may land
    wr_en = 1; wr_data = 8'hff;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; wr_en = 0;
    scan_all("R9 reset clear");
    // R3/R5/R4/R6 boundaries
    access(0, 2'd0, 7'h1f, 0, 0, 1, 8'h11);   // R2/R7 SFR write discarded
    access(0, 2'd0, 7'h20, 0, 0, 1, 8'h21);   // R3 first GPR
    access(0, 2'd0, 7'h6f, 0, 0, 1, 8'h6f);   // R3 last GPR
    access(0, 2'd1, 7'h3f, 0, 0, 1, 8'hbf);   // R5
    access(0, 2'd1, 7'h40, 0, 0, 1, 8'hc0);   // R5 wide
    access(0, 2'd1, 7'h6f, 0, 0, 1, 8'hef);   // R5 last
    access(0, 2'd2, 7'h40, 0, 0, 1, 8'h55);   // R6/R7 unimplemented write
    access(0, 2'd3, 7'h6f, 0, 0, 1, 8'h66);   // R6/R7
    access(1, 2'd0, 7'h0, 1, 8'h20, 1, 8'h77); // R6/R7 via pointer
    // R4 alias: write via bank 3, read in every bank and via pointer
    access(0, 2'd3, 7'h75, 0, 0, 1, 8'ha5);
    for (int b = 0; b < 4; b++) access(0, 2'(b), 7'h75, 0, 0, 0, 0);
    access(1, 2'd0, 7'h0, 0, 8'hf5, 0, 0);
    access(1, 2'd0, 7'h0, 1, 8'hf5, 0, 0);
    access(1, 2'd0, 7'h0, 0, 8'hf0, 1, 8'h3c); // R4 via pointer
    access(0, 2'd2, 7'h70, 0, 0, 0, 0);
    // R8: back-to-back write then read of same byte
    access(0, 2'd0, 7'h30, 0, 0, 1, 8'h9a);
    access(0, 2'd0, 7'h30, 0, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom;
      access(r[0], r[2:1], r[9:3], r[10], r[18:11], r[19], r[27:20]);
    end
    scan_all("R7 discard check");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule